// File: doc/BRIEF.md
# Deferred Fault Token Tracker

This block keeps one poison bit beside each entry of a small register file so that loads can be hoisted above branches without risking a spurious trap. A speculative load that hits a fault does not trap. It sets the poison bit of its destination instead. Speculative ALU operations carry poison from any source to their destination, so the deferred fault travels with the dependent data. A later check operation on a register does nothing if the register is clean. If the register is poisoned, the check redirects fetch to the recovery address supplied with the check.

Ordinary (non-speculative) loads and ALU operations trap at once when they fault or read a poisoned source. A clean write from either kind clears the destination's poison. The block sees one operation per cycle. Its redirect and exception outputs are registered and appear in the cycle after the operation is presented. Data values, memory and the recovery code itself are handled elsewhere.

Top module: `deferred_fault_tracker`

## Requirements
- R1: A speculative load (op_kind 2, source src_a) with op_fault set or a poisoned src_a poisons dst and never raises op_exc. Otherwise it clears dst.
- R2: A speculative ALU op (op_kind 4, sources src_a and src_b) with any poisoned source or op_fault set poisons dst and raises no op_exc. Otherwise it clears dst.
- R3: A check (op_kind 5, register src_a) on a clean register produces neither redir_valid nor op_exc.
- R4: A check on a poisoned register raises redir_valid for exactly one cycle, in the cycle after the check, with redir_addr equal to that check's rec_target. The check leaves every poison bit unchanged.
- R5: After a fault on a speculative load, one check at the end of a chain of dependent speculative ALU ops redirects.
- R6: A normal load (op_kind 1) with op_fault set or a poisoned src_a raises op_exc in the next cycle and leaves dst's poison bit unchanged.
- R7: A normal ALU op (op_kind 3) with op_fault set or any poisoned source raises op_exc in the next cycle and leaves dst's poison bit unchanged.
- R8: A normal load or ALU op that raises no exception clears the poison bit of dst.
- R9: Reset (synchronous, active high) clears all poison bits and holds redir_valid and op_exc low.
- R10: Register 0 is never poisoned, so a check on register 0 never redirects.
- R11: With op_valid low, or with op_kind 0, 6 or 7, no poison bit changes and no output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | 0 none, 1 load, 2 speculative load, 3 ALU, 4 speculative ALU, 5 check |
| src_a | input | 5 | First source register index (also the check register) |
| src_b | input | 5 | Second source register index (ALU ops only) |
| dst | input | 5 | Destination register index |
| op_fault | input | 1 | The operation itself would fault |
| rec_target | input | ADDR_W | Recovery address carried by a check |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_addr | output | ADDR_W | Redirect target |
| op_exc | output | 1 | Architectural exception for the previous operation |

## Verification
The stimulus has three parts. Directed chains start from one speculative fault and end in a check, which shows whether poison really propagates through several hops or is lost at an intermediate write. Clean overwrites of poisoned registers and trapping normal ops on poisoned destinations separate "clear on clean write" from "unchanged on trap". Random traffic confined to eight registers, with a high fault rate, produces dense read-after-write reuse and mixes every opcode, including unused codes and idle cycles. A bench model predicts every output from the requirements alone.

// File: rtl/dft_pkg.sv
package dft_pkg;

  typedef enum logic [2:0] {
    K_NONE      = 3'd0,
    K_LOAD      = 3'd1,
    K_LOAD_SPEC = 3'd2,
    K_ALU       = 3'd3,
    K_ALU_SPEC  = 3'd4,
    K_CHECK     = 3'd5
  } op_kind_e;

  typedef struct packed {
    logic wr;        // update destination poison bit
    logic wr_poison; // value to write
    logic exc;       // architectural exception now
    logic redir;     // recovery redirect
  } verdict_t;

endpackage

// File: rtl/dft_token_file.sv
module dft_token_file #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_a,
  output logic             rd_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val
);

  logic [NREG-1:0] tok_q;

  for (genvar g = 0; g < NREG; g++) begin : g_tok
    if (g == 0) begin : g_zero
      assign tok_q[g] = 1'b0;
    end else begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          tok_q[g] <= 1'b0;
        else if (wr_en && (wr_idx == IDX_W'(g)))
          tok_q[g] <= wr_val;
      end
    end
  end

  assign rd_a = tok_q[rd_a_idx];
  assign rd_b = tok_q[rd_b_idx];

endmodule

// File: rtl/dft_judge.sv
module dft_judge
  import dft_pkg::*;
(
  input  logic     op_valid,
  input  logic [2:0] op_kind,
  input  logic     poison_a,
  input  logic     poison_b,
  input  logic     op_fault,
  output verdict_t verdict
);

  logic bad_one;
  logic bad_two;

  assign bad_one = poison_a | op_fault;
  assign bad_two = poison_a | poison_b | op_fault;

  always_comb begin
    verdict = '0;
    if (op_valid) begin
      unique case (op_kind)
        K_LOAD: begin
          verdict.exc       = bad_one;
          verdict.wr        = ~bad_one;
          verdict.wr_poison = 1'b0;
        end
        K_LOAD_SPEC: begin
          verdict.wr        = 1'b1;
          verdict.wr_poison = bad_one;
        end
        K_ALU: begin
          verdict.exc       = bad_two;
          verdict.wr        = ~bad_two;
          verdict.wr_poison = 1'b0;
        end
        K_ALU_SPEC: begin
          verdict.wr        = 1'b1;
          verdict.wr_poison = bad_two;
        end
        K_CHECK: begin
          verdict.redir = poison_a;
        end
        default: verdict = '0;
      endcase
    end
  end

endmodule

// File: rtl/dft_outcome.sv
module dft_outcome #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_d,
  input  logic              exc_d,
  input  logic [ADDR_W-1:0] target_d,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              op_exc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      op_exc      <= 1'b0;
    end else begin
      redir_valid <= redir_d;
      redir_addr  <= redir_d ? target_d : '0;
      op_exc      <= exc_d;
    end
  end

endmodule

// File: rtl/deferred_fault_tracker.sv
module deferred_fault_tracker
  import dft_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  input  logic [IDX_W-1:0]  dst,
  input  logic              op_fault,
  input  logic [ADDR_W-1:0] rec_target,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              op_exc
);

  logic     poison_a;
  logic     poison_b;
  verdict_t verdict;

  dft_token_file #(.NREG(NREG), .IDX_W(IDX_W)) u_tokens (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (src_a),
    .rd_b_idx (src_b),
    .rd_a     (poison_a),
    .rd_b     (poison_b),
    .wr_en    (verdict.wr),
    .wr_idx   (dst),
    .wr_val   (verdict.wr_poison)
  );

  dft_judge u_judge (
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .poison_a (poison_a),
    .poison_b (poison_b),
    .op_fault (op_fault),
    .verdict  (verdict)
  );

  dft_outcome #(.ADDR_W(ADDR_W)) u_outcome (
    .clk         (clk),
    .rst         (rst),
    .redir_d     (verdict.redir),
    .exc_d       (verdict.exc),
    .target_d    (rec_target),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .op_exc      (op_exc)
  );

endmodule

// File: rtl/dft_checker.sv
module dft_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_kind,
  input logic [ADDR_W-1:0] rec_target,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              op_exc
);

  // R9: outputs quiet in the cycle following reset
  a_r9_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!redir_valid && !op_exc));

  // R4: a redirect only follows a valid check
  a_r4_redir_from_check: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> ($past(op_valid) && $past(op_kind) == 3'd5));

  // R4: redirect carries the check's recovery address
  a_r4_redir_target: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (redir_addr == $past(rec_target)));

  // R1 / R2: speculative ops never trap
  a_r1_spec_silent: assert property (@(posedge clk) disable iff (rst)
    op_exc |-> ($past(op_valid) && ($past(op_kind) == 3'd1 || $past(op_kind) == 3'd3)));

  // R3: one operation never both traps and redirects
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(redir_valid && op_exc));

endmodule

bind deferred_fault_tracker dft_checker #(.ADDR_W(ADDR_W)) u_dft_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_kind     (op_kind),
  .rec_target  (rec_target),
  .redir_valid (redir_valid),
  .redir_addr  (redir_addr),
  .op_exc      (op_exc)
);

// File: tb/test_deferred_fault_tracker.sv
`timescale 1ns/1ps
module test_deferred_fault_tracker;

  localparam int NREG   = 32;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              op_valid = 1'b0;
  logic [2:0]        op_kind = '0;
  logic [4:0]        src_a = '0, src_b = '0, dst = '0;
  logic              op_fault = 1'b0;
  logic [ADDR_W-1:0] rec_target = '0;
  logic              redir_valid;
  logic [ADDR_W-1:0] redir_addr;
  logic              op_exc;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit model_tok [NREG];

  always #10 clk = ~clk;

  deferred_fault_tracker #(.NREG(NREG), .ADDR_W(ADDR_W)) i_deferred_fault_tracker (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .src_a(src_a), .src_b(src_b), .dst(dst), .op_fault(op_fault),
    .rec_target(rec_target), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .op_exc(op_exc)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input bit v, input logic [2:0] k, input bit pa);
    if (!v) return "R11";
    case (k)
      3'd1: return "R6";
      3'd2: return "R1";
      3'd3: return "R7";
      3'd4: return "R2";
      3'd5: return pa ? "R4" : "R3";
      default: return "R11";
    endcase
  endfunction

  // drive one op at negedge, check outputs at the following negedge
  task automatic do_op(input bit v, input logic [2:0] k, input logic [4:0] a,
                       input logic [4:0] b, input logic [4:0] d, input bit f,
                       input logic [ADDR_W-1:0] tgt, input string tag);
    bit pa, pb, e_exc, e_red, wr, wv;
    string t;
    pa = model_tok[a]; pb = model_tok[b];
    e_exc = 0; e_red = 0; wr = 0; wv = 0;
    if (v) begin
      case (k)
        3'd1: begin e_exc = pa | f; wr = !e_exc; wv = 0; end
        3'd2: begin wr = 1; wv = pa | f; end
        3'd3: begin e_exc = pa | pb | f; wr = !e_exc; wv = 0; end
        3'd4: begin wr = 1; wv = pa | pb | f; end
        3'd5: e_red = pa;
        default: ;
      endcase
    end
    t = (tag == "") ? tag_of(v, k, pa) : tag;
    op_valid = v; op_kind = k; src_a = a; src_b = b; dst = d;
    op_fault = f; rec_target = tgt;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0;
    check(op_exc == e_exc, {t, " exc"}, op_exc, e_exc);
    check(redir_valid == e_red, {t, " redir"}, redir_valid, e_red);
    if (e_red) check(redir_addr == tgt, {t, " redir_addr"}, redir_addr, tgt);
    if (wr && d != 0) model_tok[d] = wv;
  endtask

  task automatic chk_reg(input logic [4:0] r, input bit exp_p, input string tag);
    model_tok[r] = exp_p;
    do_op(1, 3'd5, r, 0, 0, 0, 32'hC0DE_0000 + 32'(r), tag);
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(!redir_valid && !op_exc, "R9 outputs in reset", {redir_valid, op_exc}, 0);
    rst = 0;
    foreach (model_tok[i]) model_tok[i] = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    for (int r = 0; r < NREG; r++) chk_reg(5'(r), 0, "R9");

    // R5: chain from one speculative fault
    do_op(1, 3'd2, 5'd7, 0, 5'd3, 1, 0, "R1");
    do_op(1, 3'd4, 5'd3, 5'd5, 5'd4, 0, 0, "R2");
    do_op(1, 3'd4, 5'd1, 5'd4, 5'd6, 0, 0, "R2");
    do_op(1, 3'd4, 5'd6, 5'd2, 5'd9, 0, 0, "R2");
    do_op(1, 3'd5, 5'd9, 0, 0, 0, 32'h0000_4A40, "R5");
    do_op(1, 3'd5, 5'd9, 0, 0, 0, 32'h0000_4B00, "R4 token kept");
    do_op(1, 3'd5, 5'd5, 0, 0, 0, 32'h1, "R3");
    // R7: normal ALU reads poison: trap, dst unchanged
    do_op(1, 3'd3, 5'd3, 5'd0, 5'd9, 0, 0, "R7");
    do_op(1, 3'd5, 5'd9, 0, 0, 0, 32'h77, "R7 dst kept");
    // R6: normal load fault: trap, no token
    do_op(1, 3'd1, 5'd1, 0, 5'd12, 1, 0, "R6");
    do_op(1, 3'd5, 5'd12, 0, 0, 0, 32'h12, "R6 no token");
    do_op(1, 3'd1, 5'd3, 0, 5'd9, 0, 0, "R6 poison src");
    do_op(1, 3'd5, 5'd9, 0, 0, 0, 32'h99, "R6 dst kept");
    // R8: clean writes clear poison
    do_op(1, 3'd1, 5'd1, 0, 5'd9, 0, 0, "R8");
    do_op(1, 3'd5, 5'd9, 0, 0, 0, 32'h9, "R8 cleared by load");
    do_op(1, 3'd3, 5'd1, 5'd2, 5'd4, 0, 0, "R8");
    do_op(1, 3'd5, 5'd4, 0, 0, 0, 32'h4, "R8 cleared by alu");
    // R10: register 0
    do_op(1, 3'd2, 5'd1, 0, 5'd0, 1, 0, "R10");
    do_op(1, 3'd5, 5'd0, 0, 0, 0, 32'hDEAD, "R10");
    // R11: idle and unused codes
    do_op(0, 3'd2, 5'd1, 0, 5'd14, 1, 0, "R11");
    do_op(1, 3'd6, 5'd3, 5'd3, 5'd6, 1, 0, "R11");
    do_op(1, 3'd7, 5'd3, 5'd3, 5'd6, 1, 0, "R11");
    do_op(1, 3'd0, 5'd3, 5'd3, 5'd6, 1, 0, "R11");
    do_op(1, 3'd5, 5'd14, 0, 0, 0, 32'hE, "R11 idle no write");
    do_op(1, 3'd5, 5'd6, 0, 0, 0, 32'h6, "R11 code no write");
    // back-to-back checks: two separate pulses (R4)
    do_op(1, 3'd5, 5'd3, 0, 0, 0, 32'hAAAA, "R4 first");
    do_op(1, 3'd5, 5'd3, 0, 0, 0, 32'hBBBB, "R4 second");
    do_op(1, 3'd0, 0, 0, 0, 0, 0, "R4 pulse ends");

    for (int n = 0; n < 4000; n++) begin
      bit v;
      v = ($urandom % 8) != 0;
      do_op(v, 3'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8),
            5'($urandom % 8), ($urandom % 4) == 0, $urandom, "");
    end

    // R9: reset mid-run clears all poison
    do_op(1, 3'd2, 5'd1, 0, 5'd20, 1, 0, "R1");
    do_reset();
    for (int r = 0; r < NREG; r++) chk_reg(5'(r), 0, "R9 after run");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule